// File: doc/BRIEF.md
# Operand Address and Fetch Unit

This unit serves a one-address accumulator processor. When the processor has read an instruction, it hands the unit three things: a three-bit mode code, the word that follows the opcode in the instruction stream, and the current value of the X index register. The unit works out where the operand lives, reads memory as many times as the mode needs, and returns the operand with a one-cycle completion strobe.

Six modes are supported: immediate, absolute, indexed, indirect, and two that combine indirection with indexing. One of these adds X to the vector after the vector is read. The other adds X to the pointer address before the vector is read. Reads go out on a simple port that uses a request and an acknowledge. The request stays up, with a fixed address, until memory acknowledges it, and the read data is taken in the acknowledge cycle. Address sums wrap at the width of the address.

Top module: `opaddr_unit`

## Requirements
- R1: Mode code 0 (immediate) returns the instruction word as the operand. `done` is high in the cycle after the accepted `start`, and no memory request is made.
- R2: Mode code 1 (absolute) makes one read, at the instruction word, and the operand is the data returned.
- R3: Mode code 2 (indexed) makes one read, at instruction word plus X, and the operand is the data returned.
- R4: Mode code 3 (indirect) first reads a vector at the instruction word. It then reads the operand at the address given by that vector.
- R5: Mode code 4 (indexing after indirection) reads the vector at the instruction word. It then reads the operand at vector plus X.
- R6: Mode code 5 (indexing before indirection) reads the vector at instruction word plus X. It then reads the operand at that vector.
- R7: All address sums are unsigned and wrap modulo 2^ADDR_W. X is treated as unsigned.
- R8: `mem_req` stays high, and `mem_addr` stays unchanged, until `mem_ack` arrives. Read data is taken in the `mem_ack` cycle. Each read with d wait cycles takes d+1 cycles, and `done` rises in the cycle after the final acknowledge.
- R9: `done` is a single-cycle pulse. `operand` holds its value until the next request finishes.
- R10: A `start` that arrives while `busy` is high is ignored. The request in progress finishes with its own addresses and result.
- R11: Mode codes 6 and 7 raise `err` together with `done` in the cycle after `start`. They make no memory request and set `operand` to zero. `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operand fetch (accepted only when idle) |
| mode | input | 3 | Addressing mode code |
| arg | input | DATA_W | Word that follows the opcode in the instruction stream |
| xreg | input | ADDR_W | Current X index register value |
| busy | output | 1 | A fetch is in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | DATA_W | Memory read data |
| done | output | 1 | One-cycle completion strobe |
| operand | output | DATA_W | Fetched operand |
| err | output | 1 | Undefined mode code, valid with done |

## Verification
Wrong internal state shows at the memory port first. A wrong address register appears on `mem_addr` in the cycle the request is raised. A wrong flag for whether X is added to the vector appears one acknowledge later, on the second read. A sequencer that takes the wrong path changes how many reads are made, and therefore the cycle in which `done` rises. The bench checks that cycle exactly against the number of reads and the wait cycles. A mode decode that treats an undefined code as legal would raise `mem_req` in the very next cycle.

// File: rtl/amu_pkg.sv
package amu_pkg;

    localparam logic [2:0] MODE_IMM       = 3'd0;
    localparam logic [2:0] MODE_ABS       = 3'd1;
    localparam logic [2:0] MODE_IDX       = 3'd2;
    localparam logic [2:0] MODE_IND       = 3'd3;
    localparam logic [2:0] MODE_IND_POSTX = 3'd4;
    localparam logic [2:0] MODE_PREX_IND  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_OPND = 2'd2
    } amu_state_e;

    // What a mode code asks of the sequencer
    typedef struct packed {
        logic legal;   // code is defined
        logic imm;     // operand comes straight from the instruction word
        logic vec;     // a vector read comes first
        logic pre_x;   // X is added before the first read
        logic post_x;  // X is added to the vector
    } amu_plan_t;

    function automatic amu_plan_t amu_decode(input logic [2:0] m);
        amu_plan_t p;
        p = '0;
        case (m)
            MODE_IMM:       begin p.legal = 1'b1; p.imm = 1'b1; end
            MODE_ABS:       begin p.legal = 1'b1; end
            MODE_IDX:       begin p.legal = 1'b1; p.pre_x = 1'b1; end
            MODE_IND:       begin p.legal = 1'b1; p.vec = 1'b1; end
            MODE_IND_POSTX: begin p.legal = 1'b1; p.vec = 1'b1; p.post_x = 1'b1; end
            MODE_PREX_IND:  begin p.legal = 1'b1; p.vec = 1'b1; p.pre_x = 1'b1; end
            default:        p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/amu_adder.sv
module amu_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    // Unsigned, modulo 2^W
    assign sum = a + b;
endmodule

// File: rtl/amu_ctrl.sv
module amu_ctrl
    import amu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic [2:0] mode,
    input  logic      mem_ack,
    output logic      busy,
    output logic      mem_req,
    output logic      accept,
    output amu_plan_t plan_now,
    output logic      post_x,
    output logic      vec_ack,
    output logic      op_ack
);
    amu_state_e state_q, state_d;
    logic       post_x_q;

    assign plan_now = amu_decode(mode);
    assign accept   = start && (state_q == ST_IDLE);
    assign busy     = (state_q != ST_IDLE);
    assign mem_req  = (state_q == ST_VEC) || (state_q == ST_OPND);
    assign vec_ack  = (state_q == ST_VEC)  && mem_ack;
    assign op_ack   = (state_q == ST_OPND) && mem_ack;
    assign post_x   = post_x_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (accept && plan_now.legal && !plan_now.imm)
                    state_d = plan_now.vec ? ST_VEC : ST_OPND;
            end
            ST_VEC:  if (mem_ack) state_d = ST_OPND;
            ST_OPND: if (mem_ack) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            post_x_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) post_x_q <= plan_now.post_x;
        end
    end
endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
    import amu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [DATA_W-1:0] arg,
    input  logic [ADDR_W-1:0] xreg,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] operand,
    output logic              err
);
    localparam int AW = ADDR_W;

    logic              accept, post_x, vec_ack, op_ack;
    amu_plan_t         plan_now;
    logic [AW-1:0]     addr_q, x_q, add_a, add_b, sum;
    logic [AW-1:0]     arg_addr, vec_addr;
    logic [DATA_W-1:0] operand_q;
    logic              done_q, err_q;

    amu_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode     (mode),
        .mem_ack  (mem_ack),
        .busy     (busy),
        .mem_req  (mem_req),
        .accept   (accept),
        .plan_now (plan_now),
        .post_x   (post_x),
        .vec_ack  (vec_ack),
        .op_ack   (op_ack)
    );

    assign arg_addr = arg[AW-1:0];
    assign vec_addr = mem_rdata[AW-1:0];

    // One adder serves both indexing points: the instruction word plus X
    // at accept time, and the vector plus X when the vector returns.
    assign add_a = vec_ack ? vec_addr : arg_addr;
    assign add_b = vec_ack ? x_q      : xreg;

    amu_adder #(.W(AW)) u_add (
        .a   (add_a),
        .b   (add_b),
        .sum (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            x_q       <= '0;
            operand_q <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept) begin
                x_q    <= xreg;
                addr_q <= plan_now.pre_x ? sum : arg_addr;
                if (!plan_now.legal) begin
                    operand_q <= '0;
                    done_q    <= 1'b1;
                    err_q     <= 1'b1;
                end else if (plan_now.imm) begin
                    operand_q <= arg;
                    done_q    <= 1'b1;
                end
            end
            if (vec_ack)
                addr_q <= post_x ? sum : vec_addr;
            if (op_ack) begin
                operand_q <= mem_rdata;
                done_q    <= 1'b1;
            end
        end
    end

    assign mem_addr = addr_q;
    assign operand  = operand_q;
    assign done     = done_q;
    assign err      = err_q;
endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [2:0]        mode,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              done,
    input logic              err,
    input logic [DATA_W-1:0] operand
);
    a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_operand_hold: assert property (@(posedge clk) disable iff (rst)
        (!done && !busy && !start) |=> $stable(operand));

    a_r11_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    a_r1_imm_direct: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode == 3'd0) |=> (done && !err && !mem_req));

    a_r11_bad_mode: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && mode > 3'd5) |=> (done && err && !mem_req));

    a_r10_req_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
endmodule

bind opaddr_unit amu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mode     (mode),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .done     (done),
    .err      (err),
    .operand  (operand)
);

// File: tb/opaddr_unit_test.sv
module opaddr_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [15:0] arg = 16'h0;
    logic [15:0] xreg = 16'h0;
    logic        busy, mem_req, done, err;
    logic [15:0] mem_addr, operand;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'h0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int ack_delay = 0;
    int wcnt = 0;
    logic [15:0] addr_log[$];
    logic        pend = 1'b0;
    logic [15:0] pend_addr = 16'h0;
    logic        prev_done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    opaddr_unit uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .arg(arg), .xreg(xreg),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .operand(operand), .err(err)
    );

    function automatic logic [15:0] memf(input logic [15:0] a);
        return {a[7:0] ^ 8'hA5, a[15:8] + 8'h3C};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model plus per-clock protocol comparison
    always @(negedge clk) begin
        if (!rst) begin
            if (pend) chk("R8", "request held with fixed address", {15'd0, mem_req, mem_addr}, {16'd1, pend_addr});
            if (done) chk("R9", "done lasts one cycle", {31'd0, prev_done}, 32'd0);
            if (err)  chk("R11", "err only with done", {31'd0, done}, 32'd1);
        end
        prev_done = done;
        if (mem_req) begin
            if (wcnt == ack_delay) begin
                mem_ack = 1'b1;
                mem_rdata = memf(mem_addr);
                addr_log.push_back(mem_addr);
                wcnt = 0;
            end else begin
                mem_ack = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ack = 1'b0;
            wcnt = 0;
        end
        pend = mem_req && !mem_ack;
        pend_addr = mem_addr;
    end

    task automatic run_op(input string req, input logic [2:0] m, input logic [15:0] a,
                          input logic [15:0] x, input int d, input bit inject);
        logic [15:0] exp_addrs[$];
        logic [15:0] exp_op, t, v;
        logic        exp_err;
        int          n;
        exp_err = 1'b0;
        case (m)
            3'd0: exp_op = a;
            3'd1: begin exp_addrs = '{a}; exp_op = memf(a); end
            3'd2: begin t = a + x; exp_addrs = '{t}; exp_op = memf(t); end
            3'd3: begin v = memf(a); exp_addrs = '{a, v}; exp_op = memf(v); end
            3'd4: begin v = memf(a); t = v + x; exp_addrs = '{a, t}; exp_op = memf(t); end
            3'd5: begin t = a + x; v = memf(t); exp_addrs = '{t, v}; exp_op = memf(v); end
            default: begin exp_op = 16'h0; exp_err = 1'b1; end
        endcase
        ack_delay = d;
        addr_log.delete();
        @(negedge clk);
        start = 1'b1; mode = m; arg = a; xreg = x;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (inject && busy) begin   // R10: should be ignored
            start = 1'b1; mode = 3'd0; arg = 16'hDEAD; xreg = 16'h1111;
        end
        n = 0;
        while (!done && n < 500) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        chk(req, "cycles to done", n, exp_addrs.size() * (d + 1));
        chk(req, "operand", {16'd0, operand}, {16'd0, exp_op});
        chk(req, "err flag", {31'd0, err}, {31'd0, exp_err});
        chk(req, "read count", addr_log.size(), exp_addrs.size());
        foreach (exp_addrs[i])
            if (i < addr_log.size()) chk(req, "read address", {16'd0, addr_log[i]}, {16'd0, exp_addrs[i]});
        @(posedge clk);
        @(negedge clk);
        chk("R9", "done low after pulse", {31'd0, done}, 32'd0);
        chk("R9", "operand held", {16'd0, operand}, {16'd0, exp_op});
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9", "reset done", {31'd0, done}, 32'd0);
        chk("R11", "reset err", {31'd0, err}, 32'd0);
        chk("R8", "reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R10", "reset busy", {31'd0, busy}, 32'd0);
        chk("R9", "reset operand", {16'd0, operand}, 32'd0);

        run_op("R1", 3'd0, 16'h1234, 16'h0005, 0, 0);
        run_op("R2", 3'd1, 16'h0040, 16'h0007, 0, 0);
        run_op("R2", 3'd1, 16'h0A0B, 16'h0000, 2, 0);
        run_op("R3", 3'd2, 16'h0100, 16'h0023, 0, 0);
        run_op("R3", 3'd2, 16'h2000, 16'h0345, 3, 0);
        run_op("R4", 3'd3, 16'h0055, 16'h0009, 0, 0);
        run_op("R4", 3'd3, 16'h7F01, 16'h0009, 2, 0);
        run_op("R5", 3'd4, 16'h0300, 16'h0011, 0, 0);
        run_op("R5", 3'd4, 16'h4321, 16'h0100, 1, 0);
        run_op("R6", 3'd5, 16'h0300, 16'h0011, 0, 0);
        run_op("R6", 3'd5, 16'h1000, 16'h0234, 2, 0);
        run_op("R7", 3'd2, 16'hFFF0, 16'h0020, 0, 0);
        run_op("R7", 3'd5, 16'hFF00, 16'h0180, 1, 0);
        run_op("R7", 3'd4, 16'h00C3, 16'hFFFF, 0, 0);
        run_op("R10", 3'd3, 16'h0777, 16'h0003, 3, 1);
        run_op("R10", 3'd6, 16'h0777, 16'h0003, 0, 1);
        run_op("R11", 3'd6, 16'h0101, 16'h0001, 0, 0);
        run_op("R1", 3'd0, 16'hBEEF, 16'h0000, 0, 0);
        run_op("R11", 3'd7, 16'h0202, 16'h0002, 0, 0);
        run_op("R8", 3'd5, 16'h0042, 16'h0001, 4, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule